// File: doc/BRIEF.md
# Command-Parameter Program Bank Mapper

This block is the processor-side register port and program-memory banking unit of a cartridge mapper. Software configures it in two steps. First it writes a command number into one address window. Then it writes a parameter byte into a second window, and that second write triggers the command. Four of the sixteen commands belong to this block: one configures the low data window, which can hold ROM, RAM or nothing, and three select the ROM banks of the upper switchable windows. Every parameter write is also sent out as a one-cycle strobe together with its command number and byte, so that sibling blocks (pattern banking, timer) can decode the commands they own.

On every access the block turns the processor address into the upper program-memory address lines. It also drives the ROM enable, the RAM enable, and a flag that marks a read which no memory drives. The top window is fixed to the last ROM bank, which is derived from a size parameter. The block samples write cycles once per bus cycle, on the falling edge of the cycle strobe, using the block clock, which is much faster than that strobe.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset the command latch and all bank registers are 0, the low window is set to ROM with RAM off, and no parameter strobe is active. So a read of $6000 enables ROM with bank 0.
- R2: A write anywhere in $8000-$9FFF stores data bits 3:0 as the command number. Bits 7:4 are ignored.
- R3: A write anywhere in $A000-$BFFF raises `par_wr_o` for exactly one clock, in the clock after the cycle-strobe edge is seen. During that clock `par_cmd_o` carries the latched command and `par_data_o` carries the full data byte.
- R4: Commands 9, A and B load parameter bits 5:0 as the bank for $8000-$9FFF, $A000-$BFFF and $C000-$DFFF respectively. `prg_bank_o` shows that bank on any access in the matching window.
- R5: Any access in $E000-$FFFF puts bank ROM_BANKS-1 on `prg_bank_o`.
- R6: Command 8 sets up the $6000-$7FFF window. Parameter bit 7 enables RAM, bit 6 selects RAM (1) or ROM (0), and bits 5:0 give the bank. With bit 6 at 0, a read enables ROM at that bank.
- R7: With bits 7:6 at 11, reads and writes in $6000-$7FFF assert `prg_ram_ce_o`, and the bank number still appears on `prg_bank_o`.
- R8: With bits 7:6 at 01, a read in $6000-$7FFF asserts `open_bus_o` and enables neither memory.
- R9: A register write takes effect only on a falling edge of the cycle strobe with R/W low. If the strobe stays low or R/W is high, the write changes nothing.
- R10: Commands 0-7 and C-F leave every bank setting of this block unchanged.
- R11: `prg_rom_ce_o` is asserted only on reads. A write in ROM space never enables the ROM, so register writes do not conflict with ROM data.
- R12: Accesses below $6000 assert no enable and no open-bus flag, and they never change the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, faster than the cycle strobe |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | Processor address |
| cpu_data_i | input | 8 | Processor write data |
| cpu_rw_i | input | 1 | 1 = read, 0 = write |
| cpu_m2_i | input | 1 | Bus cycle strobe; writes are taken on its falling edge |
| prg_bank_o | output | BANK_W | Upper program-memory address (8 KB bank number) |
| prg_rom_ce_o | output | 1 | Program ROM enable |
| prg_ram_ce_o | output | 1 | Program RAM enable |
| open_bus_o | output | 1 | Read that no memory drives |
| par_wr_o | output | 1 | One-clock strobe for each parameter write |
| par_cmd_o | output | 4 | Command number that goes with the strobe |
| par_data_o | output | 8 | Parameter byte that goes with the strobe |

## Verification
A corrupted command latch or bank register does not show until software reads a window that uses it. A wrong bank number then appears on `prg_bank_o` right away, in the same cycle as the access. A low-window configuration that is wrong shows as the wrong enable, or as a missing or extra open-bus flag, on the first read of $6000-$7FFF. A fault in the edge detector shows one clock after the strobe falls: `par_wr_o` comes too early, too late or twice, or the bank changes when the strobe never fell.

// File: rtl/prg_map_pkg.sv
package prg_map_pkg;
  localparam int unsigned MAX_BANK_W = 6;

  localparam logic [3:0] CMD_LOW_WIN = 4'h8;
  localparam logic [3:0] CMD_BANK_A  = 4'h9;
  localparam logic [3:0] CMD_BANK_B  = 4'hA;
  localparam logic [3:0] CMD_BANK_C  = 4'hB;

  typedef enum logic [2:0] {
    WIN_NONE,
    WIN_LOW,
    WIN_SW0,
    WIN_SW1,
    WIN_SW2,
    WIN_FIXED
  } win_e;

  typedef struct packed {
    logic                  ram_en;
    logic                  ram_sel;
    logic [MAX_BANK_W-1:0] bank;
  } low_cfg_t;

  function automatic win_e decode_win(input logic [2:0] hi);
    case (hi)
      3'b011:  return WIN_LOW;
      3'b100:  return WIN_SW0;
      3'b101:  return WIN_SW1;
      3'b110:  return WIN_SW2;
      3'b111:  return WIN_FIXED;
      default: return WIN_NONE;
    endcase
  endfunction
endpackage

// File: rtl/prg_wr_detect.sv
module prg_wr_detect (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       m2_i,
  input  logic       rw_i,
  input  logic [2:0] addr_hi_i,
  output logic       cmd_wr_o,
  output logic       par_wr_o
);
  logic m2_q;
  logic fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m2_q <= 1'b0;
    else         m2_q <= m2_i;
  end

  assign fall     = m2_q & ~m2_i & ~rw_i;
  assign cmd_wr_o = fall & (addr_hi_i == 3'b100);
  assign par_wr_o = fall & (addr_hi_i == 3'b101);
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_map_pkg::*;
#(
  parameter int unsigned BANK_W = 6
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_wr_i,
  input  logic                   par_wr_i,
  input  logic [7:0]             data_i,
  output low_cfg_t               low_cfg_o,
  output logic [2:0][BANK_W-1:0] sw_bank_o,
  output logic                   par_wr_o,
  output logic [3:0]             par_cmd_o,
  output logic [7:0]             par_data_o
);
  logic [3:0] cmd_q;
  low_cfg_t   low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmd_q <= '0;
    else if (cmd_wr_i) cmd_q <= data_i[3:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_q <= '0;
    end else if (par_wr_i && cmd_q == CMD_LOW_WIN) begin
      low_q.ram_en  <= data_i[7];
      low_q.ram_sel <= data_i[6];
      low_q.bank    <= data_i[MAX_BANK_W-1:0];
    end
  end
  assign low_cfg_o = low_q;

  for (genvar i = 0; i < 3; i++) begin : g_sw
    localparam logic [3:0] MY_CMD = CMD_BANK_A + 4'(i);
    logic [BANK_W-1:0] bank_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         bank_q <= '0;
      else if (par_wr_i && cmd_q == MY_CMD) bank_q <= data_i[BANK_W-1:0];
    end
    assign sw_bank_o[i] = bank_q;
  end

  // forward every parameter write to sibling decoders
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_wr_o   <= 1'b0;
      par_cmd_o  <= '0;
      par_data_o <= '0;
    end else begin
      par_wr_o <= par_wr_i;
      if (par_wr_i) begin
        par_cmd_o  <= cmd_q;
        par_data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/prg_window_decode.sv
module prg_window_decode
  import prg_map_pkg::*;
#(
  parameter int unsigned BANK_W    = 6,
  parameter int unsigned ROM_BANKS = 32
) (
  input  logic [2:0]             addr_hi_i,
  input  logic                   rw_i,
  input  low_cfg_t               low_cfg_i,
  input  logic [2:0][BANK_W-1:0] sw_bank_i,
  output logic [BANK_W-1:0]      bank_o,
  output logic                   rom_ce_o,
  output logic                   ram_ce_o,
  output logic                   open_bus_o
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(ROM_BANKS - 1);

  win_e win;
  assign win = decode_win(addr_hi_i);

  always_comb begin
    bank_o     = '0;
    rom_ce_o   = 1'b0;
    ram_ce_o   = 1'b0;
    open_bus_o = 1'b0;
    unique case (win)
      WIN_LOW: begin
        bank_o = low_cfg_i.bank[BANK_W-1:0];
        if (!low_cfg_i.ram_sel)    rom_ce_o   = rw_i;
        else if (low_cfg_i.ram_en) ram_ce_o   = 1'b1;
        else                       open_bus_o = rw_i;
      end
      WIN_SW0: begin bank_o = sw_bank_i[0]; rom_ce_o = rw_i; end
      WIN_SW1: begin bank_o = sw_bank_i[1]; rom_ce_o = rw_i; end
      WIN_SW2: begin bank_o = sw_bank_i[2]; rom_ce_o = rw_i; end
      WIN_FIXED: begin bank_o = LAST_BANK; rom_ce_o = rw_i; end
      default: ;
    endcase
  end
endmodule

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper
  import prg_map_pkg::*;
#(
  parameter int unsigned BANK_W    = 6,
  parameter int unsigned ROM_BANKS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_rw_i,
  input  logic              cpu_m2_i,
  output logic [BANK_W-1:0] prg_bank_o,
  output logic              prg_rom_ce_o,
  output logic              prg_ram_ce_o,
  output logic              open_bus_o,
  output logic              par_wr_o,
  output logic [3:0]        par_cmd_o,
  output logic [7:0]        par_data_o
);
  logic                   cmd_wr;
  logic                   par_wr;
  low_cfg_t               low_cfg;
  logic [2:0][BANK_W-1:0] sw_bank;

  prg_wr_detect u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .m2_i      (cpu_m2_i),
    .rw_i      (cpu_rw_i),
    .addr_hi_i (cpu_addr_i[15:13]),
    .cmd_wr_o  (cmd_wr),
    .par_wr_o  (par_wr)
  );

  prg_bank_regs #(.BANK_W(BANK_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_wr_i   (cmd_wr),
    .par_wr_i   (par_wr),
    .data_i     (cpu_data_i),
    .low_cfg_o  (low_cfg),
    .sw_bank_o  (sw_bank),
    .par_wr_o   (par_wr_o),
    .par_cmd_o  (par_cmd_o),
    .par_data_o (par_data_o)
  );

  prg_window_decode #(.BANK_W(BANK_W), .ROM_BANKS(ROM_BANKS)) u_dec (
    .addr_hi_i  (cpu_addr_i[15:13]),
    .rw_i       (cpu_rw_i),
    .low_cfg_i  (low_cfg),
    .sw_bank_i  (sw_bank),
    .bank_o     (prg_bank_o),
    .rom_ce_o   (prg_rom_ce_o),
    .ram_ce_o   (prg_ram_ce_o),
    .open_bus_o (open_bus_o)
  );
endmodule

// File: rtl/prg_bank_mapper_chk.sv
module prg_bank_mapper_chk
  import prg_map_pkg::*;
#(
  parameter int unsigned BANK_W    = 6,
  parameter int unsigned ROM_BANKS = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [15:0]            cpu_addr_i,
  input logic                   cpu_rw_i,
  input logic                   cpu_m2_i,
  input logic [BANK_W-1:0]      prg_bank_o,
  input logic                   prg_rom_ce_o,
  input logic                   prg_ram_ce_o,
  input logic                   open_bus_o,
  input logic                   par_wr_o,
  input logic                   par_wr,
  input low_cfg_t               low_cfg,
  input logic [2:0][BANK_W-1:0] sw_bank
);
  a_r3_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_wr_o |=> !par_wr_o);

  a_r3_strobe_follows_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_wr |=> par_wr_o);

  a_r5_fixed_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b111) |-> (prg_bank_o == BANK_W'(ROM_BANKS - 1)));

  a_r8_one_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({prg_rom_ce_o, prg_ram_ce_o, open_bus_o}) <= 1);

  a_r9_no_edge_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!par_wr || cpu_m2_i) |=> ($stable(low_cfg) && $stable(sw_bank)));

  a_r11_rom_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_rw_i |-> !prg_rom_ce_o);

  a_r12_low_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] < 3'b011) |-> !(prg_rom_ce_o || prg_ram_ce_o || open_bus_o));
endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(.BANK_W(BANK_W), .ROM_BANKS(ROM_BANKS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_addr_i   (cpu_addr_i),
  .cpu_rw_i     (cpu_rw_i),
  .cpu_m2_i     (cpu_m2_i),
  .prg_bank_o   (prg_bank_o),
  .prg_rom_ce_o (prg_rom_ce_o),
  .prg_ram_ce_o (prg_ram_ce_o),
  .open_bus_o   (open_bus_o),
  .par_wr_o     (par_wr_o),
  .par_wr       (par_wr),
  .low_cfg      (low_cfg),
  .sw_bank      (sw_bank)
);

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;
  localparam int unsigned BANK_W    = 6;
  localparam int unsigned ROM_BANKS = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       addr = '0;
  logic [7:0]        data = '0;
  logic              rw = 1'b1;
  logic              m2 = 1'b0;
  logic [BANK_W-1:0] bank;
  logic              rom_ce, ram_ce, ob;
  logic              pwr;
  logic [3:0]        pcmd;
  logic [7:0]        pdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic       s_wr;
  logic [3:0] s_cmd;
  logic [7:0] s_data;

  always #2 clk = ~clk;

  prg_bank_mapper #(.BANK_W(BANK_W), .ROM_BANKS(ROM_BANKS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
    .cpu_rw_i(rw), .cpu_m2_i(m2), .prg_bank_o(bank), .prg_rom_ce_o(rom_ce),
    .prg_ram_ce_o(ram_ce), .open_bus_o(ob), .par_wr_o(pwr),
    .par_cmd_o(pcmd), .par_data_o(pdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // full bus write cycle; snapshot strobe one clock after the strobe edge
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; data = d; rw = 1'b0; m2 = 1'b1;
    @(negedge clk);
    m2 = 1'b0;
    @(negedge clk);
    s_wr = pwr; s_cmd = pcmd; s_data = pdata;
    @(negedge clk);
    chk(pwr == 1'b0, "R3 strobe width", pwr, 0);
    rw = 1'b1; addr = 16'h0000;
  endtask

  task automatic cfg(input logic [3:0] c, input logic [7:0] p);
    bus_write(16'h8000, {4'h0, c});
    bus_write(16'hA000, p);
  endtask

  task automatic look(input logic [15:0] a, input logic r);
    @(negedge clk); addr = a; rw = r; #1;
  endtask

  task automatic expect_rom(input logic [15:0] a, input int b, input string req);
    look(a, 1'b1);
    chk(bank == BANK_W'(b), req, bank, b);
    chk(rom_ce && !ram_ce && !ob, req, {rom_ce, ram_ce, ob}, 3'b100);
  endtask

  task automatic t_reset;
    expect_rom(16'h6000, 0, "R1 low window");
    expect_rom(16'h8000, 0, "R1 bank A");
    chk(pwr == 1'b0, "R1 no strobe", pwr, 0);
  endtask

  task automatic t_switch_banks;
    bus_write(16'h9FFF, 8'hF9);   // upper nibble ignored
    bus_write(16'hBFFF, 8'hC5);
    chk(s_wr && s_cmd == 4'h9 && s_data == 8'hC5, "R2 R3 strobe",
        {s_wr, s_cmd, s_data}, {1'b1, 4'h9, 8'hC5});
    expect_rom(16'h8123, 5, "R4 cmd9");
    cfg(4'hA, 8'h2A);
    expect_rom(16'hA7FF, 8'h2A, "R4 cmdA");
    cfg(4'hB, 8'h3F);
    expect_rom(16'hDFFF, 8'h3F, "R4 cmdB");
    expect_rom(16'hE000, ROM_BANKS - 1, "R5 fixed");
    expect_rom(16'hFFFF, ROM_BANKS - 1, "R5 fixed top");
  endtask

  task automatic t_low_window;
    cfg(4'h8, 8'h87);
    expect_rom(16'h6000, 7, "R6 rom select");
    cfg(4'h8, 8'hC3);
    look(16'h7FFF, 1'b1);
    chk(ram_ce && !rom_ce && !ob && bank == 6'd3, "R7 ram read",
        {ram_ce, rom_ce, ob, bank}, {3'b100, 6'd3});
    look(16'h6800, 1'b0);
    chk(ram_ce && bank == 6'd3, "R7 ram write", {ram_ce, bank}, {1'b1, 6'd3});
    cfg(4'h8, 8'h45);
    look(16'h6000, 1'b1);
    chk(ob && !rom_ce && !ram_ce, "R8 open bus", {ob, rom_ce, ram_ce}, 3'b100);
    look(16'h6000, 1'b0);
    chk(!ram_ce && !rom_ce, "R8 write blocked", {rom_ce, ram_ce}, 0);
  endtask

  task automatic t_other_cmds;
    cfg(4'h3, 8'h11);
    cfg(4'hD, 8'hFF);
    chk(s_wr && s_cmd == 4'hD && s_data == 8'hFF, "R10 forwarded",
        {s_wr, s_cmd, s_data}, {1'b1, 4'hD, 8'hFF});
    expect_rom(16'h8000, 5, "R10 bank A kept");
    expect_rom(16'hA000, 8'h2A, "R10 bank B kept");
    look(16'h6000, 1'b1);
    chk(ob && bank == 6'd5, "R10 low kept", {ob, bank}, {1'b1, 6'd5});
  endtask

  task automatic t_no_edge;
    bus_write(16'h8000, 8'h09);
    // strobe held low with a write pending: no effect
    @(negedge clk); addr = 16'hA000; data = 8'h01; rw = 1'b0; m2 = 1'b0;
    repeat (4) @(negedge clk);
    chk(pwr == 1'b0, "R9 no strobe", pwr, 0);
    // strobe falls during a read: no effect
    rw = 1'b1; m2 = 1'b1;
    @(negedge clk); m2 = 1'b0;
    repeat (2) @(negedge clk);
    chk(pwr == 1'b0, "R9 read edge", pwr, 0);
    expect_rom(16'h8000, 5, "R9 bank kept");
  endtask

  task automatic t_low_addr;
    look(16'h4020, 1'b1);
    chk(!rom_ce && !ram_ce && !ob, "R12 quiet read", {rom_ce, ram_ce, ob}, 0);
    bus_write(16'h5000, 8'h0A);
    bus_write(16'h2000, 8'h3C);
    chk(s_wr == 1'b0, "R12 no strobe", s_wr, 0);
    expect_rom(16'h8000, 5, "R12 bank kept");
  endtask

  task automatic t_rom_write;
    look(16'hC000, 1'b0);
    chk(!rom_ce && !ram_ce, "R11 rom write", {rom_ce, ram_ce}, 0);
    look(16'hE000, 1'b0);
    chk(!rom_ce && bank == 6'(ROM_BANKS - 1), "R11 fixed write",
        {rom_ce, bank}, ROM_BANKS - 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_switch_banks();
    t_low_window();
    t_other_cmds();
    t_no_edge();
    t_low_addr();
    t_rom_write();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule